// File: doc/BRIEF.md
# Interrupt Acknowledge and Activation Unit

This block serves one processor's interrupt interface at the moment that processor reads its acknowledge register. It receives the interrupt that the external arbiter selected as most urgent, with that interrupt's ID, 8-bit priority, group and routing model. It compares the priority with the processor's current running priority and either accepts the interrupt or answers with the spurious ID 1023. A lower priority value is more urgent.

When the interrupt is accepted, the unit returns its ID. For software-generated interrupts the ID also carries the number of the sending processor. The unit issues one-cycle strobes that tell the external pending/active store what to clear and what to mark active. It also holds the processor's own priority state: two sets of active-priority bits (one for group 0, one for group 1) and the running priority. The priority used for that state is reduced by a binary point, and which binary point applies depends on the interrupt's group.

Top module: `irq_ack_unit`

## Requirements
- R1: If `ack_req` is high while `pend_valid` is low, the response is ID 1023 in `ack_data[9:0]` with bits 12:10 zero. No update strobe is raised and no priority state changes.
- R2: If the offered priority is greater than or equal to `running_prio`, the response is 1023. `running_prio`, `apr_bits` and `nsapr_bits` keep their values and no update strobe is raised.
- R3: The group priority is the offered priority ANDed with 8'hFF shifted left by (bp + 1), where bp is the 3-bit binary point in use. With bp = 7 the group priority is 0.
- R4: The binary point in use is `abpr - 1` when `groups_en` is 1, `cbpr` is 0 and the interrupt is group 1. In that case an `abpr` of 0 counts as 0. In every other case the binary point in use is `bpr`.
- R5: On acceptance, exactly one active-priority bit is set, at index level = the top log2(NUM_LEVELS) bits of the group priority (with 32 levels, group priority >> 3). The bit goes into `nsapr_bits` when `groups_en` is 1 and the interrupt is group 1, and into `apr_bits` otherwise.
- R6: On acceptance, `running_prio` becomes the group priority. `set_active_valid` is raised and `upd_id` carries the ID.
- R7: An accepted ID below 16 is software-generated. The unit picks the lowest set bit of `pend_sgi_src`, returns that bit's index in `ack_data[12:10]`, and raises `sgi_src_clr_valid` with a one-hot `sgi_src_clr_mask` naming only that bit.
- R8: For a software-generated ID, `clr_pend_valid` is raised only when no other source bit remains set. Its mask is then the own processor's bit alone, whatever `pend_one_of_n` says.
- R9: For an accepted ID of 16 or more, `clr_pend_valid` is raised and `ack_data[12:10]` is zero. `clr_pend_mask` is all ones when `pend_one_of_n` is 1, and only bit CPU_IDX otherwise.
- R10: After a synchronous reset, `running_prio` is 8'hFF, both active-priority sets are zero and every strobe is low.
- R11: `ack_valid` is high in the cycle after each cycle with `ack_req` high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ack_req | input | 1 | Acknowledge read request, one cycle |
| pend_valid | input | 1 | An interrupt is offered |
| pend_id | input | 10 | Offered interrupt ID |
| pend_prio | input | 8 | Offered priority, lower is more urgent |
| pend_grp1 | input | 1 | Offered interrupt is group 1 |
| pend_one_of_n | input | 1 | Offered interrupt uses the one-of-N routing model |
| pend_sgi_src | input | NUM_CPUS | Pending source bits of an offered software-generated ID |
| groups_en | input | 1 | Interrupt groups are supported |
| cbpr | input | 1 | Common binary point for both groups |
| bpr | input | 3 | Primary binary point |
| abpr | input | 3 | Group 1 (aliased) binary point |
| ack_valid | output | 1 | Response valid, one cycle |
| ack_data | output | 13 | Returned ID with source number in bits 12:10 |
| upd_id | output | 10 | ID addressed by the update strobes |
| clr_pend_valid | output | 1 | Clear the pending flag of `upd_id` |
| clr_pend_mask | output | NUM_CPUS | Processors whose pending flag is cleared |
| sgi_src_clr_valid | output | 1 | Clear one source bit of `upd_id` |
| sgi_src_clr_mask | output | NUM_CPUS | One-hot source bit to clear |
| set_active_valid | output | 1 | Mark `upd_id` active for this processor |
| running_prio | output | 8 | Current running priority |
| apr_bits | output | NUM_LEVELS | Group 0 active-priority bits |
| nsapr_bits | output | NUM_LEVELS | Group 1 active-priority bits |

## Verification
The hardest case to reach is the group-1 binary point path with an aliased binary point of zero. It shows only when groups are on, the common-binary-point bit is off, and the group 1 interrupt's priority has a low bit that the two candidate masks treat differently. The bench sets those controls after a reset and offers a priority such as 0x47, so each wrong choice of binary point gives a different running priority and a different active-priority index. Preemption nesting is reached by acknowledging interrupts of ever more urgent priority without a reset in between. This builds several active-priority bits in both sets and lets equal-priority offers be checked for refusal.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    localparam int ID_W     = 10;
    localparam int PRIO_W   = 8;
    localparam int SRC_W    = 3;
    localparam int DATA_W   = ID_W + SRC_W;
    localparam int SGI_LAST = 15;

    localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
    localparam logic [PRIO_W-1:0] IDLE_PRIO   = 8'hFF;

    typedef struct packed {
        logic              groups_en;
        logic              cbpr;
        logic [2:0]        bpr;
        logic [2:0]        abpr;
    } bp_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
        logic              grp1;
        logic              one_of_n;
    } offer_t;

    typedef enum logic [1:0] {
        RESP_SPURIOUS,
        RESP_SGI,
        RESP_PLAIN
    } resp_kind_t;

    // Binary point actually applied to an interrupt of the given group.
    function automatic logic [2:0] pick_bp(input bp_cfg_t cfg, input logic grp1);
        if (cfg.groups_en && !cfg.cbpr && grp1) begin
            return (cfg.abpr == 3'd0) ? 3'd0 : cfg.abpr - 3'd1;
        end
        return cfg.bpr;
    endfunction

    // Keeps the priority bits above the binary point.
    function automatic logic [PRIO_W-1:0] bp_mask(input logic [2:0] bp);
        logic [3:0] sh;
        sh = {1'b0, bp} + 4'd1;
        return 8'hFF << sh;
    endfunction

endpackage

// File: rtl/ack_prio_calc.sv
module ack_prio_calc
    import irq_ack_pkg::*;
#(
    parameter int NUM_LEVELS = 32,
    localparam int LVL_W = $clog2(NUM_LEVELS)
) (
    input  logic [PRIO_W-1:0] prio,
    input  logic              grp1,
    input  bp_cfg_t           cfg,
    output logic [PRIO_W-1:0] gprio,
    output logic [LVL_W-1:0]  level,
    output logic              use_ns
);
    logic [2:0] bp;

    always_comb begin
        bp     = pick_bp(cfg, grp1);
        gprio  = prio & bp_mask(bp);
        level  = gprio[PRIO_W-1 -: LVL_W];
        use_ns = cfg.groups_en && grp1;
    end
endmodule

// File: rtl/ack_sgi_pick.sv
module ack_sgi_pick
    import irq_ack_pkg::*;
#(
    parameter int NUM_CPUS = 4
) (
    input  logic [NUM_CPUS-1:0] src_bits,
    output logic [SRC_W-1:0]    src_idx,
    output logic [NUM_CPUS-1:0] src_onehot,
    output logic                none_left
);
    logic [NUM_CPUS-1:0] rest;

    always_comb begin
        src_idx    = '0;
        src_onehot = '0;
        for (int i = NUM_CPUS - 1; i >= 0; i--) begin
            if (src_bits[i]) begin
                src_idx    = SRC_W'(i);
                src_onehot = NUM_CPUS'(1) << i;
            end
        end
        rest      = src_bits & ~src_onehot;
        none_left = (rest == '0);
    end
endmodule

// File: rtl/ack_active_state.sv
module ack_active_state
    import irq_ack_pkg::*;
#(
    parameter int NUM_LEVELS = 32,
    localparam int LVL_W = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  set_en,
    input  logic                  set_ns,
    input  logic [LVL_W-1:0]      level,
    input  logic [PRIO_W-1:0]     new_prio,
    output logic [PRIO_W-1:0]     running_prio,
    output logic [NUM_LEVELS-1:0] apr_bits,
    output logic [NUM_LEVELS-1:0] nsapr_bits
);
    logic [NUM_LEVELS-1:0] lvl_onehot;

    always_comb lvl_onehot = NUM_LEVELS'(1) << level;

    always_ff @(posedge clk) begin
        if (rst) begin
            running_prio <= IDLE_PRIO;
            apr_bits     <= '0;
            nsapr_bits   <= '0;
        end else if (set_en) begin
            running_prio <= new_prio;
            if (set_ns) nsapr_bits <= nsapr_bits | lvl_onehot;
            else        apr_bits   <= apr_bits | lvl_onehot;
        end
    end

    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !set_en |=> ($stable(running_prio) && $stable(apr_bits) && $stable(nsapr_bits))); // R2

    AST_ONE_LEVEL_BIT: assert property (@(posedge clk) disable iff (rst)
        set_en |=> (($countones(apr_bits ^ $past(apr_bits))
                   + $countones(nsapr_bits ^ $past(nsapr_bits))) <= 1)); // R5
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
    import irq_ack_pkg::*;
#(
    parameter int NUM_CPUS   = 4,
    parameter int CPU_IDX    = 0,
    parameter int NUM_LEVELS = 32,
    localparam int LVL_W = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ack_req,
    input  logic                  pend_valid,
    input  logic [ID_W-1:0]       pend_id,
    input  logic [PRIO_W-1:0]     pend_prio,
    input  logic                  pend_grp1,
    input  logic                  pend_one_of_n,
    input  logic [NUM_CPUS-1:0]   pend_sgi_src,
    input  logic                  groups_en,
    input  logic                  cbpr,
    input  logic [2:0]            bpr,
    input  logic [2:0]            abpr,
    output logic                  ack_valid,
    output logic [DATA_W-1:0]     ack_data,
    output logic [ID_W-1:0]       upd_id,
    output logic                  clr_pend_valid,
    output logic [NUM_CPUS-1:0]   clr_pend_mask,
    output logic                  sgi_src_clr_valid,
    output logic [NUM_CPUS-1:0]   sgi_src_clr_mask,
    output logic                  set_active_valid,
    output logic [PRIO_W-1:0]     running_prio,
    output logic [NUM_LEVELS-1:0] apr_bits,
    output logic [NUM_LEVELS-1:0] nsapr_bits
);
    localparam logic [NUM_CPUS-1:0] OWN_MASK = NUM_CPUS'(1) << CPU_IDX;

    offer_t              offer;
    bp_cfg_t             cfg;
    resp_kind_t          kind;
    logic [PRIO_W-1:0]   gprio;
    logic [LVL_W-1:0]    level;
    logic                use_ns;
    logic [SRC_W-1:0]    src_idx;
    logic [NUM_CPUS-1:0] src_onehot;
    logic                none_left;
    logic                take;
    logic [DATA_W-1:0]   data_nxt;
    logic                clr_nxt;
    logic [NUM_CPUS-1:0] clr_mask_nxt;

    always_comb begin
        offer = '{valid: pend_valid, id: pend_id, prio: pend_prio,
                  grp1: pend_grp1, one_of_n: pend_one_of_n};
        cfg   = '{groups_en: groups_en, cbpr: cbpr, bpr: bpr, abpr: abpr};
    end

    ack_prio_calc #(.NUM_LEVELS(NUM_LEVELS)) u_prio (
        .prio   (offer.prio),
        .grp1   (offer.grp1),
        .cfg    (cfg),
        .gprio  (gprio),
        .level  (level),
        .use_ns (use_ns)
    );

    ack_sgi_pick #(.NUM_CPUS(NUM_CPUS)) u_sgi (
        .src_bits   (pend_sgi_src),
        .src_idx    (src_idx),
        .src_onehot (src_onehot),
        .none_left  (none_left)
    );

    always_comb begin
        take = ack_req && offer.valid && (offer.prio < running_prio);
        if (!take)                          kind = RESP_SPURIOUS;
        else if (offer.id <= ID_W'(SGI_LAST)) kind = RESP_SGI;
        else                                kind = RESP_PLAIN;

        data_nxt     = {{SRC_W{1'b0}}, SPURIOUS_ID};
        clr_nxt      = 1'b0;
        clr_mask_nxt = OWN_MASK;
        unique case (kind)
            RESP_SGI: begin
                data_nxt = {src_idx, offer.id};
                clr_nxt  = none_left;
            end
            RESP_PLAIN: begin
                data_nxt     = {{SRC_W{1'b0}}, offer.id};
                clr_nxt      = 1'b1;
                clr_mask_nxt = offer.one_of_n ? {NUM_CPUS{1'b1}} : OWN_MASK;
            end
            default: ;
        endcase
    end

    ack_active_state #(.NUM_LEVELS(NUM_LEVELS)) u_state (
        .clk          (clk),
        .rst          (rst),
        .set_en       (take),
        .set_ns       (use_ns),
        .level        (level),
        .new_prio     (gprio),
        .running_prio (running_prio),
        .apr_bits     (apr_bits),
        .nsapr_bits   (nsapr_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_valid         <= 1'b0;
            ack_data          <= '0;
            upd_id            <= '0;
            clr_pend_valid    <= 1'b0;
            clr_pend_mask     <= '0;
            sgi_src_clr_valid <= 1'b0;
            sgi_src_clr_mask  <= '0;
            set_active_valid  <= 1'b0;
        end else begin
            ack_valid         <= ack_req;
            ack_data          <= data_nxt;
            upd_id            <= offer.id;
            clr_pend_valid    <= clr_nxt;
            clr_pend_mask     <= clr_mask_nxt;
            sgi_src_clr_valid <= (kind == RESP_SGI) && (pend_sgi_src != '0);
            sgi_src_clr_mask  <= src_onehot;
            set_active_valid  <= take;
        end
    end

    AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_data[ID_W-1:0] == SPURIOUS_ID)
        |-> (!set_active_valid && !clr_pend_valid && !sgi_src_clr_valid)); // R1

    AST_PRIO_RISES: assert property (@(posedge clk) disable iff (rst)
        set_active_valid |-> (running_prio < $past(running_prio))); // R6

    AST_SGI_ONE_SRC: assert property (@(posedge clk) disable iff (rst)
        sgi_src_clr_valid |-> ($countones(sgi_src_clr_mask) == 1
                               && upd_id <= ID_W'(SGI_LAST))); // R7

    AST_CLR_HAS_OWN: assert property (@(posedge clk) disable iff (rst)
        clr_pend_valid |-> clr_pend_mask[CPU_IDX]); // R9

    AST_RESP_NEXT: assert property (@(posedge clk) disable iff (rst)
        ack_req |=> ack_valid); // R11
endmodule

// File: tb/irq_ack_unit_tb.sv
module irq_ack_unit_tb;
    localparam int NC = 4;
    localparam int NL = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ack_req = 1'b0, pend_valid = 1'b0, pend_grp1 = 1'b0, pend_one_of_n = 1'b0;
    logic [9:0] pend_id = '0;
    logic [7:0] pend_prio = '0;
    logic [NC-1:0] pend_sgi_src = '0;
    logic groups_en = 1'b0, cbpr = 1'b0;
    logic [2:0] bpr = 3'd2, abpr = 3'd3;
    logic ack_valid, clr_pend_valid, sgi_src_clr_valid, set_active_valid;
    logic [12:0] ack_data;
    logic [9:0] upd_id;
    logic [NC-1:0] clr_pend_mask, sgi_src_clr_mask;
    logic [7:0] running_prio;
    logic [NL-1:0] apr_bits, nsapr_bits;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_ack_unit #(.NUM_CPUS(NC), .CPU_IDX(2), .NUM_LEVELS(NL)) u_dut (
        .clk(clk), .rst(rst), .ack_req(ack_req), .pend_valid(pend_valid),
        .pend_id(pend_id), .pend_prio(pend_prio), .pend_grp1(pend_grp1),
        .pend_one_of_n(pend_one_of_n), .pend_sgi_src(pend_sgi_src),
        .groups_en(groups_en), .cbpr(cbpr), .bpr(bpr), .abpr(abpr),
        .ack_valid(ack_valid), .ack_data(ack_data), .upd_id(upd_id),
        .clr_pend_valid(clr_pend_valid), .clr_pend_mask(clr_pend_mask),
        .sgi_src_clr_valid(sgi_src_clr_valid), .sgi_src_clr_mask(sgi_src_clr_mask),
        .set_active_valid(set_active_valid), .running_prio(running_prio),
        .apr_bits(apr_bits), .nsapr_bits(nsapr_bits)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Offer one interrupt and pulse ack_req; returns at the negedge where the response is visible.
    task automatic ack(input logic vld, input logic [9:0] id, input logic [7:0] pr,
                       input logic g1, input logic o1n, input logic [NC-1:0] src);
        @(negedge clk);
        pend_valid = vld; pend_id = id; pend_prio = pr;
        pend_grp1 = g1; pend_one_of_n = o1n; pend_sgi_src = src;
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R10 running_prio", running_prio, 8'hFF);
        check("R10 apr_bits", apr_bits, 0);
        check("R10 nsapr_bits", nsapr_bits, 0);
        check("R10 strobes", {ack_valid, clr_pend_valid, sgi_src_clr_valid, set_active_valid}, 0);
    endtask

    task automatic t_nothing_pending();
        do_reset();
        ack(1'b0, 10'd40, 8'h10, 1'b0, 1'b0, '0);
        check("R11 ack_valid", ack_valid, 1);
        check("R1 data", ack_data, 13'd1023);
        check("R1 strobes", {clr_pend_valid, sgi_src_clr_valid, set_active_valid}, 0);
        @(negedge clk);
        check("R11 ack_valid drops", ack_valid, 0);
        check("R1 running_prio", running_prio, 8'hFF);
    endtask

    task automatic t_nesting();
        do_reset();
        groups_en = 1'b0; cbpr = 1'b0; bpr = 3'd2; abpr = 3'd3;
        ack(1'b1, 10'd40, 8'h45, 1'b0, 1'b0, '0);
        check("R9 data", ack_data, 13'd40);
        check("R6 set_active", {set_active_valid, upd_id}, {1'b1, 10'd40});
        check("R3 running_prio", running_prio, 8'h40);
        check("R5 apr level 8", apr_bits, 32'h100);
        check("R9 clr own", {clr_pend_valid, clr_pend_mask}, {1'b1, 4'b0100});
        check("R7 no sgi clr", sgi_src_clr_valid, 0);
        ack(1'b1, 10'd41, 8'h40, 1'b0, 1'b0, '0);
        check("R2 equal prio data", ack_data, 13'd1023);
        check("R2 equal prio strobes", {clr_pend_valid, set_active_valid}, 0);
        check("R2 equal prio state", {running_prio, apr_bits}, {8'h40, 32'h100});
        ack(1'b1, 10'd42, 8'h50, 1'b0, 1'b0, '0);
        check("R2 lower prio data", ack_data, 13'd1023);
        groups_en = 1'b1;
        ack(1'b1, 10'd77, 8'h17, 1'b1, 1'b0, '0);
        check("R4 grp1 abpr-1 running", running_prio, 8'h10);
        check("R5 nsapr level 2", {nsapr_bits, apr_bits}, {32'h4, 32'h100});
        ack(1'b1, 10'd100, 8'h08, 1'b0, 1'b1, '0);
        check("R9 one-of-n mask", {clr_pend_valid, clr_pend_mask}, {1'b1, 4'b1111});
        check("R5 apr level 1", apr_bits, 32'h102);
    endtask

    task automatic t_bp_select();
        do_reset();
        groups_en = 1'b1; cbpr = 1'b1; bpr = 3'd0; abpr = 3'd7;
        ack(1'b1, 10'd50, 8'h47, 1'b1, 1'b0, '0);
        check("R4 cbpr uses bpr", running_prio, 8'h46);
        check("R5 cbpr grp1 in nsapr", {nsapr_bits, apr_bits}, {32'h100, 32'h0});
        do_reset();
        groups_en = 1'b0; cbpr = 1'b0; bpr = 3'd0; abpr = 3'd7;
        ack(1'b1, 10'd50, 8'h47, 1'b1, 1'b0, '0);
        check("R4 groups off uses bpr", running_prio, 8'h46);
        check("R5 groups off in apr", {nsapr_bits, apr_bits}, {32'h0, 32'h100});
        do_reset();
        groups_en = 1'b1; cbpr = 1'b0; bpr = 3'd7; abpr = 3'd0;
        ack(1'b1, 10'd50, 8'h47, 1'b1, 1'b0, '0);
        check("R4 abpr zero clamps", running_prio, 8'h46);
        check("R5 abpr zero nsapr", nsapr_bits, 32'h100);
    endtask

    task automatic t_bp_seven();
        do_reset();
        groups_en = 1'b0; cbpr = 1'b0; bpr = 3'd7;
        ack(1'b1, 10'd60, 8'h9C, 1'b0, 1'b0, '0);
        check("R3 bp7 running zero", running_prio, 8'h00);
        check("R5 bp7 level 0", apr_bits, 32'h1);
        ack(1'b1, 10'd61, 8'h00, 1'b0, 1'b0, '0);
        check("R2 prio 0 vs running 0", ack_data, 13'd1023);
    endtask

    task automatic t_sgi();
        do_reset();
        groups_en = 1'b0; bpr = 3'd2;
        ack(1'b1, 10'd5, 8'h20, 1'b0, 1'b0, 4'b1010);
        check("R7 data src 1", ack_data, 13'h405);
        check("R7 src clr", {sgi_src_clr_valid, sgi_src_clr_mask}, {1'b1, 4'b0010});
        check("R8 pending kept", clr_pend_valid, 0);
        ack(1'b1, 10'd5, 8'h10, 1'b0, 1'b1, 4'b1000);
        check("R7 data src 3", ack_data, 13'hC05);
        check("R7 src clr last", {sgi_src_clr_valid, sgi_src_clr_mask}, {1'b1, 4'b1000});
        check("R8 pending cleared own", {clr_pend_valid, clr_pend_mask}, {1'b1, 4'b0100});
        ack(1'b1, 10'd15, 8'h08, 1'b0, 1'b0, 4'b0001);
        check("R7 id 15 src 0", ack_data, 13'd15);
        check("R8 id 15 last source", clr_pend_valid, 1);
        ack(1'b1, 10'd16, 8'h00, 1'b0, 1'b0, 4'b1111);
        check("R9 id 16 no src field", ack_data, 13'd16);
        check("R9 id 16 no sgi clr", sgi_src_clr_valid, 0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_nothing_pending();
        t_nesting();
        t_bp_select();
        t_bp_seven();
        t_sgi();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule